// File: doc/BRIEF.md
# Processor Power-Domain Bring-Up Sequencer

This block is a hardware state machine that takes a processor core's power domain from a held, clamped, unpowered condition to a running core. One start pulse launches a fixed series of steps. The block holds the core in reset, turns on the oscillator clock branch and waits for that branch to report itself running. It then switches on the domain's head switch and bypasses the regulator. It releases the memory clamps and wakes the memory periphery. Next it powers the memory banks one by one, from the highest index down, releases the remaining clamps, and finally lets the core run.

Every output is a registered level that goes straight to the power switches, clamps and reset lines of the domain. Delays and poll intervals come from a microsecond tick made by dividing the system clock. The boot vector, which is the boot address shifted right by four, is captured when the sequence starts and held on an output. The block ends in one of two states. In the done state the core runs until the next start. In the error state the clock branch never reported ready, every reset stays asserted, and only a new start tries again.

Top module: `pwrup_seq`

## Requirements
- R1: A start pulse accepted while not busy sets stop-core, core reset and bus reset high and returns the head switch, LDO bypass, standby, retention, clock enable and all bank enables low, with the memory, wordline and I/O clamps high. It captures boot_addr_i[ADDR_W-1:4] on boot_vec_o. All of this is visible on the edge that accepts the start.
- R2: After start the oscillator branch enable rises. From that edge the block samples clk_off_i once every CLK_PER_US cycles, and the head switch rises only after a sample that finds clk_off_i low.
- R3: If POLL_LIMIT samples in a row find clk_off_i high, err_o rises exactly POLL_LIMIT*CLK_PER_US cycles after the oscillator enable rose. The three resets stay high, and err_o holds until the next start.
- R4: LDO bypass rises exactly CLK_PER_US cycles after the head switch rises, and never while the head switch is low.
- R5: The memory clamp falls after LDO bypass rises. L2 standby-not and retention-not then rise together, before the first bank enable.
- R6: Bank enables turn on one per step, from index NUM_BANKS-1 down to 0. They accumulate, and no enable falls during a run. Consecutive bank steps are at least CLK_PER_US cycles apart.
- R7: The wordline clamp falls at least CLK_PER_US cycles after bank 0 turns on. The I/O clamp falls strictly after the wordline clamp.
- R8: After the clamps, core reset falls, then core clock enable rises, then stop-core falls, each on a later edge. done_o rises on the edge where stop-core falls and stays high until the next start.
- R9: A start pulse that arrives while busy_o is high is ignored: the sequence continues unchanged and boot_vec_o keeps its value.
- R10: At most one of busy_o, done_o and err_o is high. busy_o is high from the accepting edge until done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| boot_addr_i | input | ADDR_W | Boot address; bits above 3 are captured |
| clk_off_i | input | 1 | High while the oscillator branch is still off |
| stop_core_o | output | 1 | Holds the core from executing |
| core_rst_o | output | 1 | Core asynchronous reset |
| bus_rst_o | output | 1 | Bus asynchronous reset enable |
| xo_en_o | output | 1 | Oscillator clock branch enable |
| head_sw_o | output | 1 | Block head switch on |
| ldo_byp_o | output | 1 | Regulator bypass |
| mem_clamp_o | output | 1 | Memory-compiler clamp |
| l2_stby_n_o | output | 1 | L2 data standby, active low |
| slp_ret_n_o | output | 1 | Sleep retention, active low |
| bank_en_o | output | NUM_BANKS | Per-bank memory power enables |
| wl_clamp_o | output | 1 | Wordline clamp |
| io_clamp_o | output | 1 | I/O clamp |
| core_clk_en_o | output | 1 | Core clock enable |
| boot_vec_o | output | ADDR_W-4 | Captured boot vector |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Core released and running |
| err_o | output | 1 | Clock-ready poll timed out |

## Verification
A corrupted state register shows up as an output that changes out of order. Examples are a bank enable turning on below one that is still off, a clamp releasing before the banks are complete, or stop-core falling with the clock still gated. Each of these is visible on the very edge where the bad step is taken. A wrong tick or poll count shows up as a shift in the cycle distance between the head switch and LDO bypass, or between the oscillator enable and err_o. That distance can be measured exactly one microsecond, or one full poll budget, after the step that started it. A start that wrongly restarts a run drops the head switch or a bank enable, or changes boot_vec_o, within one cycle.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_XO,
        ST_POLL,
        ST_HSW,
        ST_HSW_WAIT,
        ST_QMC,
        ST_STBY,
        ST_BANK,
        ST_BANK_WAIT,
        ST_WL,
        ST_IO,
        ST_CORE,
        ST_CLK,
        ST_RUN,
        ST_DONE,
        ST_ERR
    } seq_state_e;

    typedef struct packed {
        logic stop_core;
        logic core_rst;
        logic bus_rst;
        logic xo_en;
        logic head_sw;
        logic ldo_byp;
        logic mem_clamp;
        logic l2_stby_n;
        logic slp_ret_n;
        logic wl_clamp;
        logic io_clamp;
        logic core_clk_en;
    } pwr_ctl_t;

    // Held, clamped, unpowered domain
    localparam pwr_ctl_t CTL_SAFE = '{
        stop_core:   1'b1,
        core_rst:    1'b1,
        bus_rst:     1'b1,
        xo_en:       1'b0,
        head_sw:     1'b0,
        ldo_byp:     1'b0,
        mem_clamp:   1'b1,
        l2_stby_n:   1'b0,
        slp_ret_n:   1'b0,
        wl_clamp:    1'b1,
        io_clamp:    1'b1,
        core_clk_en: 1'b0
    };

endpackage

// File: rtl/pwrup_tick.sv
module pwrup_tick #(
    parameter int CLK_PER_US = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_PER_US - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || cnt_q == CNT_LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/pwrup_bank_fill.sv
module pwrup_bank_fill #(
    parameter int NUM_BANKS = 20
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clr_i,
    input  logic                 step_i,
    output logic [NUM_BANKS-1:0] en_o
);
    logic [NUM_BANKS-1:0] en_d, en_q;

    // Each step brings in a one at the top and moves the filled region down
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic src;
        if (i == NUM_BANKS - 1) begin : g_top
            assign src = 1'b1;
        end else begin : g_lower
            assign src = en_q[i+1];
        end
        assign en_d[i] = clr_i ? 1'b0 : (step_i ? src : en_q[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q;

    // A bank may be on only if every bank above it is on
    assert_bank_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q & ~{1'b1, en_q[NUM_BANKS-1:1]}) == '0);

    assert_bank_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((en_q & $past(en_q)) == $past(en_q)));

    assert_bank_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clr_i && !(&en_q)) |=> ($countones(en_q) == $countones($past(en_q)) + 1));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CLK_PER_US = 4,
    parameter int POLL_LIMIT = 200,
    parameter int NUM_BANKS  = 20,
    parameter int ADDR_W     = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    boot_addr_i,
    input  logic                 clk_off_i,
    output logic                 stop_core_o,
    output logic                 core_rst_o,
    output logic                 bus_rst_o,
    output logic                 xo_en_o,
    output logic                 head_sw_o,
    output logic                 ldo_byp_o,
    output logic                 mem_clamp_o,
    output logic                 l2_stby_n_o,
    output logic                 slp_ret_n_o,
    output logic [NUM_BANKS-1:0] bank_en_o,
    output logic                 wl_clamp_o,
    output logic                 io_clamp_o,
    output logic                 core_clk_en_o,
    output logic [ADDR_W-5:0]    boot_vec_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o
);
    localparam int VEC_SHIFT = 4;
    localparam int VEC_W     = ADDR_W - VEC_SHIFT;
    localparam int PCNT_W    = $clog2(POLL_LIMIT + 1);
    localparam int BCNT_W    = $clog2(NUM_BANKS + 1);
    localparam logic [PCNT_W-1:0] POLL_LAST = PCNT_W'(POLL_LIMIT - 1);
    localparam logic [BCNT_W-1:0] BANK_TOP  = BCNT_W'(NUM_BANKS - 1);

    typedef struct packed {
        seq_state_e        st;
        pwr_ctl_t          ctl;
        logic [PCNT_W-1:0] poll;
        logic [BCNT_W-1:0] bank;
        logic [VEC_W-1:0]  vec;
        logic              done;
        logic              err;
    } seq_regs_t;

    seq_regs_t d, q;
    logic      tick;
    logic      tick_clr;
    logic      bank_clr;
    logic      bank_step;
    logic      unused_addr_bits;

    assign unused_addr_bits = ^boot_addr_i[VEC_SHIFT-1:0];

    pwrup_tick #(
        .CLK_PER_US(CLK_PER_US)
    ) i_tick (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (tick_clr),
        .tick_o(tick)
    );

    pwrup_bank_fill #(
        .NUM_BANKS(NUM_BANKS)
    ) i_banks (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (bank_clr),
        .step_i(bank_step),
        .en_o  (bank_en_o)
    );

    always_comb begin
        d         = q;
        tick_clr  = 1'b0;
        bank_clr  = 1'b0;
        bank_step = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start_i) begin
                    d.ctl    = CTL_SAFE;
                    d.vec    = boot_addr_i[ADDR_W-1:VEC_SHIFT];
                    d.done   = 1'b0;
                    d.err    = 1'b0;
                    bank_clr = 1'b1;
                    d.st     = ST_XO;
                end
            end
            ST_XO: begin
                d.ctl.xo_en = 1'b1;
                d.poll      = '0;
                tick_clr    = 1'b1;
                d.st        = ST_POLL;
            end
            ST_POLL: begin
                if (tick) begin
                    if (!clk_off_i) begin
                        d.st = ST_HSW;
                    end else if (q.poll == POLL_LAST) begin
                        d.err = 1'b1;
                        d.st  = ST_ERR;
                    end else begin
                        d.poll = q.poll + 1'b1;
                    end
                end
            end
            ST_HSW: begin
                d.ctl.head_sw = 1'b1;
                tick_clr      = 1'b1;
                d.st          = ST_HSW_WAIT;
            end
            ST_HSW_WAIT: begin
                if (tick) begin
                    d.ctl.ldo_byp = 1'b1;
                    d.st          = ST_QMC;
                end
            end
            ST_QMC: begin
                d.ctl.mem_clamp = 1'b0;
                d.st            = ST_STBY;
            end
            ST_STBY: begin
                d.ctl.l2_stby_n = 1'b1;
                d.ctl.slp_ret_n = 1'b1;
                d.bank          = BANK_TOP;
                d.st            = ST_BANK;
            end
            ST_BANK: begin
                bank_step = 1'b1;
                tick_clr  = 1'b1;
                d.st      = ST_BANK_WAIT;
            end
            ST_BANK_WAIT: begin
                if (tick) begin
                    if (q.bank == '0) begin
                        d.st = ST_WL;
                    end else begin
                        d.bank = q.bank - 1'b1;
                        d.st   = ST_BANK;
                    end
                end
            end
            ST_WL: begin
                d.ctl.wl_clamp = 1'b0;
                d.st           = ST_IO;
            end
            ST_IO: begin
                d.ctl.io_clamp = 1'b0;
                d.st           = ST_CORE;
            end
            ST_CORE: begin
                d.ctl.core_rst = 1'b0;
                d.st           = ST_CLK;
            end
            ST_CLK: begin
                d.ctl.core_clk_en = 1'b1;
                d.st              = ST_RUN;
            end
            ST_RUN: begin
                d.ctl.stop_core = 1'b0;
                d.done          = 1'b1;
                d.st            = ST_DONE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st   <= ST_IDLE;
            q.ctl  <= CTL_SAFE;
            q.poll <= '0;
            q.bank <= '0;
            q.vec  <= '0;
            q.done <= 1'b0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign stop_core_o   = q.ctl.stop_core;
    assign core_rst_o    = q.ctl.core_rst;
    assign bus_rst_o     = q.ctl.bus_rst;
    assign xo_en_o       = q.ctl.xo_en;
    assign head_sw_o     = q.ctl.head_sw;
    assign ldo_byp_o     = q.ctl.ldo_byp;
    assign mem_clamp_o   = q.ctl.mem_clamp;
    assign l2_stby_n_o   = q.ctl.l2_stby_n;
    assign slp_ret_n_o   = q.ctl.slp_ret_n;
    assign wl_clamp_o    = q.ctl.wl_clamp;
    assign io_clamp_o    = q.ctl.io_clamp;
    assign core_clk_en_o = q.ctl.core_clk_en;
    assign boot_vec_o    = q.vec;
    assign done_o        = q.done;
    assign err_o         = q.err;
    assign busy_o        = !(q.st inside {ST_IDLE, ST_DONE, ST_ERR});

    assert_start_safe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (stop_core_o && core_rst_o && bus_rst_o && !head_sw_o
                                  && bank_en_o == '0 && io_clamp_o && busy_o));

    assert_hsw_needs_xo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        head_sw_o |-> xo_en_o);

    assert_err_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (stop_core_o && core_rst_o && bus_rst_o && !head_sw_o));

    assert_ldo_after_hsw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ldo_byp_o |-> head_sw_o);

    assert_stby_after_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        l2_stby_n_o |-> (!mem_clamp_o && ldo_byp_o && slp_ret_n_o));

    assert_wl_after_banks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wl_clamp_o |-> (&bank_en_o));

    assert_io_after_wl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !io_clamp_o |-> !wl_clamp_o);

    assert_core_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stop_core_o |-> (core_clk_en_o && !core_rst_o && !io_clamp_o));

    assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> done_o);

    assert_vec_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(boot_vec_o));

    assert_status_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({busy_o, done_o, err_o}));

endmodule

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;
    localparam int K  = 4;
    localparam int NB = 20;
    localparam int PL = 200;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic clk_off;
    logic stop_core, core_rst, bus_rst, xo_en, head_sw, ldo_byp, mem_clamp;
    logic l2_stby_n, slp_ret_n, wl_clamp, io_clamp, core_clk_en, busy, done, err;
    logic [NB-1:0] bank_en;
    logic [AW-5:0] boot_vec;

    int errors = 0;
    int checks = 0;
    int hold_cyc = 0;
    int off_cnt = 0;

    int t_xo, t_hsw, t_ldo, t_qmc, t_stby, t_wl, t_io, t_core, t_clk, t_stop, t_done, t_err, t_offlow;
    int t_bank[NB];
    bit bad_fall, bad_stat, bad_busy, inj_busy;

    always #2.5 clk = ~clk;

    // Clock-off status model: stays high for hold_cyc cycles after enable
    always @(negedge clk) off_cnt <= xo_en ? off_cnt + 1 : 0;
    assign clk_off = !xo_en || (off_cnt < hold_cyc);

    pwrup_seq #(
        .CLK_PER_US(K), .POLL_LIMIT(PL), .NUM_BANKS(NB), .ADDR_W(AW)
    ) i_pwrup_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .boot_addr_i(addr),
        .clk_off_i(clk_off), .stop_core_o(stop_core), .core_rst_o(core_rst),
        .bus_rst_o(bus_rst), .xo_en_o(xo_en), .head_sw_o(head_sw),
        .ldo_byp_o(ldo_byp), .mem_clamp_o(mem_clamp), .l2_stby_n_o(l2_stby_n),
        .slp_ret_n_o(slp_ret_n), .bank_en_o(bank_en), .wl_clamp_o(wl_clamp),
        .io_clamp_o(io_clamp), .core_clk_en_o(core_clk_en), .boot_vec_o(boot_vec),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-5:0] exp_vec(input logic [AW-1:0] a);
        return a[AW-1:4];
    endfunction

    task automatic run_seq(input logic [AW-1:0] a, input int hold, input int inj_at,
                           input logic [AW-1:0] a2, input int limit);
        logic p_xo, p_hsw, p_ldo, p_qmc, p_stby, p_wl, p_io, p_core, p_clk, p_stop, p_done, p_err;
        logic [NB-1:0] p_bank;
        hold_cyc = hold;
        t_xo = -1; t_hsw = -1; t_ldo = -1; t_qmc = -1; t_stby = -1; t_wl = -1; t_io = -1;
        t_core = -1; t_clk = -1; t_stop = -1; t_done = -1; t_err = -1; t_offlow = -1;
        for (int i = 0; i < NB; i++) t_bank[i] = -1;
        bad_fall = 0; bad_stat = 0; bad_busy = 0; inj_busy = 0;
        @(negedge clk); addr = a; start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R1: state right after the accepting edge
        check(stop_core && core_rst && bus_rst, "R1", "resets after start", {stop_core, core_rst, bus_rst}, 7);
        check(!head_sw && !ldo_byp && !core_clk_en && bank_en == '0, "R1", "power outputs off after start",
              {head_sw, ldo_byp, core_clk_en, bank_en}, 0);
        check(mem_clamp && wl_clamp && io_clamp, "R1", "clamps on after start", {mem_clamp, wl_clamp, io_clamp}, 7);
        check(boot_vec == exp_vec(a), "R1", "boot vector captured", boot_vec, exp_vec(a));
        check(busy && !done && !err, "R10", "busy after start", {busy, done, err}, 4);
        p_xo = xo_en; p_hsw = head_sw; p_ldo = ldo_byp; p_qmc = mem_clamp; p_stby = l2_stby_n;
        p_wl = wl_clamp; p_io = io_clamp; p_core = core_rst; p_clk = core_clk_en; p_stop = stop_core;
        p_done = done; p_err = err; p_bank = bank_en;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (c == inj_at) begin
                start = 1'b1; addr = a2; inj_busy = busy;
            end else begin
                start = 1'b0;
            end
            if (!clk_off && t_offlow < 0) t_offlow = c;
            if (xo_en && !p_xo) t_xo = c;
            if (head_sw && !p_hsw) t_hsw = c;
            if (ldo_byp && !p_ldo) t_ldo = c;
            if (!mem_clamp && p_qmc) t_qmc = c;
            if (l2_stby_n && !p_stby) t_stby = c;
            if (!wl_clamp && p_wl) t_wl = c;
            if (!io_clamp && p_io) t_io = c;
            if (!core_rst && p_core) t_core = c;
            if (core_clk_en && !p_clk) t_clk = c;
            if (!stop_core && p_stop) t_stop = c;
            if (done && !p_done) t_done = c;
            if (err && !p_err) t_err = c;
            for (int i = 0; i < NB; i++) if (bank_en[i] && !p_bank[i]) t_bank[i] = c;
            if ((p_bank & ~bank_en) != '0 || (p_hsw && !head_sw) || (p_xo && !xo_en)) bad_fall = 1;
            if ($countones({busy, done, err}) > 1) bad_stat = 1;
            if (!busy && !done && !err) bad_busy = 1;
            p_xo = xo_en; p_hsw = head_sw; p_ldo = ldo_byp; p_qmc = mem_clamp; p_stby = l2_stby_n;
            p_wl = wl_clamp; p_io = io_clamp; p_core = core_rst; p_clk = core_clk_en; p_stop = stop_core;
            p_done = done; p_err = err; p_bank = bank_en;
            if (done || err) break;
        end
        start = 1'b0;
    endtask

    task automatic verify_ok(input logic [AW-1:0] a);
        int min_gap;
        int order_bad;
        check(t_done > 0 && !err, "R8", "sequence reached done", t_done, 1);
        check(t_xo == 1, "R2", "oscillator enable cycle", t_xo, 1);
        check(t_offlow > 0 && t_hsw > t_offlow, "R2", "head switch after clock ready", t_hsw, t_offlow + 1);
        check(t_ldo - t_hsw == K, "R4", "head switch to bypass distance", t_ldo - t_hsw, K);
        check(t_qmc > t_ldo && t_stby > t_qmc, "R5", "clamp then standby order", t_stby, t_qmc + 1);
        check(t_bank[NB-1] > t_stby, "R5", "standby before first bank", t_bank[NB-1], t_stby + 1);
        min_gap = 1000000; order_bad = 0;
        for (int i = 0; i < NB - 1; i++) begin
            if (t_bank[i] - t_bank[i+1] < min_gap) min_gap = t_bank[i] - t_bank[i+1];
            if (t_bank[i] <= t_bank[i+1]) order_bad++;
        end
        check(order_bad == 0, "R6", "banks enabled top down", order_bad, 0);
        check(min_gap >= K, "R6", "minimum bank step spacing", min_gap, K);
        check(bank_en == '1 && !bad_fall, "R6", "all banks on, none dropped", bank_en, {NB{1'b1}});
        check(t_wl - t_bank[0] >= K, "R7", "wordline release after last bank", t_wl - t_bank[0], K);
        check(t_io > t_wl, "R7", "I/O clamp after wordline clamp", t_io, t_wl + 1);
        check(t_core > t_io && t_clk > t_core && t_stop > t_clk, "R8", "core release order", t_stop, t_clk + 1);
        check(t_done == t_stop, "R8", "done with stop-core clear", t_done, t_stop);
        check(!bad_stat && !bad_busy, "R10", "status exclusive and busy held", {bad_stat, bad_busy}, 0);
        check(boot_vec == exp_vec(a), "R9", "boot vector held to done", boot_vec, exp_vec(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(stop_core && core_rst && bus_rst && !xo_en && !head_sw && bank_en == '0,
              "R1", "reset state outputs", {stop_core, core_rst, bus_rst, xo_en, head_sw}, 28);
        check(!busy && !done && !err, "R10", "idle status after reset", {busy, done, err}, 0);

        // Directed: clock ready at once
        run_seq(32'h1000_0040, 0, -1, '0, 3000);
        verify_ok(32'h1000_0040);
        repeat (40) @(negedge clk);
        check(done && !stop_core && core_clk_en, "R8", "done held until next start", {done, stop_core}, 2);

        // Random hold times and addresses
        for (int n = 0; n < 5; n++) begin
            a = $urandom;
            run_seq(a, $urandom_range(0, 300), -1, '0, 3000);
            verify_ok(a);
        end

        // Start while busy is ignored
        run_seq(32'hCAFE_0010, 10, 25, 32'h0BAD_F00F, 3000);
        check(inj_busy, "R9", "extra start landed while busy", inj_busy, 1);
        verify_ok(32'hCAFE_0010);

        // Clock never ready: timeout
        a = 32'h2222_3330;
        run_seq(a, 1000000, -1, '0, PL * K + 100);
        check(err && !done, "R3", "error raised on timeout", {err, done}, 2);
        check(t_err - t_xo == PL * K, "R3", "timeout distance", t_err - t_xo, PL * K);
        check(stop_core && core_rst && bus_rst && !head_sw, "R3", "resets held in error",
              {stop_core, core_rst, bus_rst, head_sw}, 14);
        repeat (50) @(negedge clk);
        check(err && !busy && !head_sw, "R3", "error held without new start", {err, busy, head_sw}, 4);

        // Retry after error
        a = 32'h0000_ABC0;
        run_seq(a, 7, -1, '0, 3000);
        verify_ok(a);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule